// File: doc/BRIEF.md
# Device Property Stream Generator

When a request strobe arrives, this block sends a fixed list of device properties, one byte at a time. It is meant for the response path of a logic-analyser style capture engine. Every property is a record made of a key byte and then a value. The key byte's top three bits give the value type and its bottom five bits give the token. The type decides how the value is sent:

- **Text** (type 0): characters terminated by a zero byte.
- **Word** (type 1): four bytes, most significant first.
- **Byte** (type 2): a single byte.

After the last record, a zero key byte closes the list.

The three text values are compile-time parameters. The numeric values arrive on input ports and are sampled as each byte is presented. Bytes leave through a valid/ready pair, and a one-cycle done flag marks the end of the list. Command decoding and the serial link are outside the block.

Top module: `metaresp_gen`

## Requirements
- R1: After reset, txValid and done are both low.
- R2: A start pulse while the block is idle makes txValid high on the next cycle, and txData then carries the first key, 0x01. This keeps the response well inside a 10 ms deadline.
- R3: Each key byte is {type[2:0], token[4:0]}. Records go out in this key order: 0x01 (name text), 0x02 (firmware version text), 0x03 (auxiliary version text), 0x20 (probe count word), 0x21 (sample memory bytes word), 0x22 (dynamic memory bytes word), 0x23 (maximum sample rate in Hz, word), 0x41 (protocol version byte).
- R4: A text value is sent as its characters from first to last, then one 0x00, before the next key.
- R5: A word value is sent as four bytes, most significant first. The probe-count word is the 8-bit probeCnt input, zero-extended.
- R6: A byte value is sent as one byte, equal to protoVer.
- R7: A single 0x00 follows the last record. done is high for exactly one cycle, in the cycle after the handshake of that terminator, and txValid is low in that cycle.
- R8: While txValid is high and txReady is low, txValid stays high and txData holds its value. The stream advances only on a cycle where txValid and txReady are both high.
- R9: A start pulse that arrives while a list is being sent is ignored. The list in progress completes with exactly the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send the property list |
| probeCnt | input | 8 | Number of usable probes |
| memBytes | input | 32 | Sample memory size in bytes |
| dynBytes | input | 32 | Dynamic memory size in bytes |
| maxRateHz | input | 32 | Highest sample rate in Hz |
| protoVer | input | 8 | Protocol version |
| txReady | input | 1 | Consumer accepts txData this cycle |
| txValid | output | 1 | txData holds a byte of the list |
| txData | output | 8 | Current byte of the list |
| done | output | 1 | One-cycle pulse after the closing zero is accepted |

## Verification
The bench sends whole lists under several ready patterns and numeric value sets, and compares every accepted byte with a list it builds itself. The patterns are always ready, alternating, pseudo-random and mostly stalled.

Several faults show up as a byte mismatch or a wrong length:
- an off-by-one in the string terminator drops or duplicates a zero;
- a word sent least significant byte first reverses its bytes;
- a counter that advances under a stall skips bytes.

Stalls are checked separately for a held byte. A start pulse injected mid-list catches a design that restarts; such a design would repeat the opening key. The done check catches a pulse that is missing, too long, or raised together with valid.

// File: rtl/metaresp_pkg.sv
package metaresp_pkg;

  localparam int NUM_RECS = 8;
  localparam int REC_W = $clog2(NUM_RECS + 1);

  typedef enum logic [2:0] {
    VT_TEXT = 3'd0,
    VT_WORD = 3'd1,
    VT_BYTE = 3'd2
  } valType_e;

  // strobes from control into the datapath
  typedef struct packed {
    logic clear;
    logic enterVal;
    logic advByte;
    logic advRec;
  } stepCmd_t;

  function automatic logic [7:0] keyOf(input logic [REC_W-1:0] r);
    case (int'(r))
      0:       return {VT_TEXT, 5'd1};
      1:       return {VT_TEXT, 5'd2};
      2:       return {VT_TEXT, 5'd3};
      3:       return {VT_WORD, 5'd0};
      4:       return {VT_WORD, 5'd1};
      5:       return {VT_WORD, 5'd2};
      6:       return {VT_WORD, 5'd3};
      7:       return {VT_BYTE, 5'd1};
      default: return 8'h00;
    endcase
  endfunction

  function automatic valType_e typeOf(input logic [REC_W-1:0] r);
    logic [7:0] k;
    k = keyOf(r);
    return valType_e'(k[7:5]);
  endfunction

endpackage

// File: rtl/metaresp_datapath.sv
module metaresp_datapath
  import metaresp_pkg::*;
#(
  parameter int NAME_LEN = 4,
  parameter logic [8*NAME_LEN-1:0] NAME_TXT = "LA32",
  parameter int FW_LEN = 3,
  parameter logic [8*FW_LEN-1:0] FW_TXT = "1.0",
  parameter int AUX_LEN = 3,
  parameter logic [8*AUX_LEN-1:0] AUX_TXT = "0.9"
) (
  input  logic        clk,
  input  logic        rstN,
  input  stepCmd_t    cmd,
  input  logic [7:0]  probeCnt,
  input  logic [31:0] memBytes,
  input  logic [31:0] dynBytes,
  input  logic [31:0] maxRateHz,
  input  logic [7:0]  protoVer,
  output logic [7:0]  byteOut,
  output logic        isEnd,
  output logic        inVal,
  output logic        valLast
);

  localparam int LEN_A = (NAME_LEN > FW_LEN) ? NAME_LEN : FW_LEN;
  localparam int LEN_B = (LEN_A > AUX_LEN) ? LEN_A : AUX_LEN;
  localparam int MAXLEN = (LEN_B > 3) ? LEN_B : 3;
  localparam int IDXW = $clog2(MAXLEN + 1);

  logic [REC_W-1:0] recIdx;
  logic [IDXW-1:0]  byteIdx;
  logic             inValQ;

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) begin
      recIdx  <= '0;
      byteIdx <= '0;
      inValQ  <= 1'b0;
    end else if (cmd.enterVal) begin
      inValQ  <= 1'b1;
      byteIdx <= '0;
    end else if (cmd.advByte) begin
      byteIdx <= byteIdx + 1'b1;
    end else if (cmd.advRec) begin
      recIdx  <= recIdx + 1'b1;
      inValQ  <= 1'b0;
      byteIdx <= '0;
    end
  end

  valType_e   curType;
  logic [7:0] textCh;
  logic [IDXW-1:0] textLen;
  logic [31:0] wordVal;
  logic [7:0]  wordByte;

  always_comb begin
    curType = typeOf(recIdx);
    case (int'(recIdx))
      0: begin
        textLen = IDXW'(NAME_LEN);
        textCh  = 8'(NAME_TXT >> (8 * (NAME_LEN - 1 - int'(byteIdx))));
      end
      1: begin
        textLen = IDXW'(FW_LEN);
        textCh  = 8'(FW_TXT >> (8 * (FW_LEN - 1 - int'(byteIdx))));
      end
      default: begin
        textLen = IDXW'(AUX_LEN);
        textCh  = 8'(AUX_TXT >> (8 * (AUX_LEN - 1 - int'(byteIdx))));
      end
    endcase
    case (int'(recIdx))
      3:       wordVal = {24'd0, probeCnt};
      4:       wordVal = memBytes;
      5:       wordVal = dynBytes;
      6:       wordVal = maxRateHz;
      default: wordVal = 32'd0;
    endcase
    wordByte = 8'(wordVal >> (8 * (3 - int'(byteIdx))));

    isEnd = (int'(recIdx) == NUM_RECS);
    inVal = inValQ;
    case (curType)
      VT_TEXT: valLast = (byteIdx == textLen);
      VT_WORD: valLast = (int'(byteIdx) == 3);
      default: valLast = 1'b1;
    endcase

    if (isEnd)        byteOut = 8'h00;
    else if (!inValQ) byteOut = keyOf(recIdx);
    else begin
      case (curType)
        VT_TEXT: byteOut = (byteIdx == textLen) ? 8'h00 : textCh;
        VT_WORD: byteOut = wordByte;
        default: byteOut = protoVer;
      endcase
    end
  end

endmodule

// File: rtl/metaresp_ctrl.sv
module metaresp_ctrl
  import metaresp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     txReady,
  input  logic     isEnd,
  input  logic     inVal,
  input  logic     valLast,
  output stepCmd_t cmd,
  output logic     txValid,
  output logic     done
);

  logic busy;
  logic fire;

  assign fire    = busy && txReady;
  assign txValid = busy;

  always_comb begin
    cmd = '0;
    if (!busy && start)  cmd.clear = 1'b1;
    else if (fire && !isEnd) begin
      if (!inVal)        cmd.enterVal = 1'b1;
      else if (valLast)  cmd.advRec = 1'b1;
      else               cmd.advByte = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fire && isEnd;
      if (!busy && start)      busy <= 1'b1;
      else if (fire && isEnd)  busy <= 1'b0;
    end
  end

endmodule

// File: rtl/metaresp_gen.sv
module metaresp_gen
  import metaresp_pkg::*;
#(
  parameter int NAME_LEN = 4,
  parameter logic [8*NAME_LEN-1:0] NAME_TXT = "LA32",
  parameter int FW_LEN = 3,
  parameter logic [8*FW_LEN-1:0] FW_TXT = "1.0",
  parameter int AUX_LEN = 3,
  parameter logic [8*AUX_LEN-1:0] AUX_TXT = "0.9"
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  probeCnt,
  input  logic [31:0] memBytes,
  input  logic [31:0] dynBytes,
  input  logic [31:0] maxRateHz,
  input  logic [7:0]  protoVer,
  input  logic        txReady,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        done
);

  stepCmd_t cmd;
  logic isEnd, inVal, valLast;

  metaresp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .txReady(txReady),
    .isEnd(isEnd), .inVal(inVal), .valLast(valLast),
    .cmd(cmd), .txValid(txValid), .done(done)
  );

  metaresp_datapath #(
    .NAME_LEN(NAME_LEN), .NAME_TXT(NAME_TXT),
    .FW_LEN(FW_LEN), .FW_TXT(FW_TXT),
    .AUX_LEN(AUX_LEN), .AUX_TXT(AUX_TXT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .probeCnt(probeCnt), .memBytes(memBytes), .dynBytes(dynBytes),
    .maxRateHz(maxRateHz), .protoVer(protoVer),
    .byteOut(txData), .isEnd(isEnd), .inVal(inVal), .valLast(valLast)
  );

endmodule

// File: rtl/metaresp_checker.sv
module metaresp_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       txReady,
  input logic       txValid,
  input logic [7:0] txData,
  input logic       done
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData));

  p_first_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    start && !txValid |=> txValid && txData == 8'h01);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !txValid);

  p_done_after_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(txValid && txReady && txData == 8'h00));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && start |=> txValid && $stable(txData));

endmodule

bind metaresp_gen metaresp_checker chk_i (
  .clk(clk), .rstN(rstN), .start(start), .txReady(txReady),
  .txValid(txValid), .txData(txData), .done(done)
);

// File: tb/metaresp_gen_tb.sv
module metaresp_gen_tb_top;

  localparam int NL = 5;
  localparam logic [8*NL-1:0] NT = "Sniff";
  localparam int FL = 3;
  localparam logic [8*FL-1:0] FT = "3.1";
  localparam int AL = 2;
  localparam logic [8*AL-1:0] AT = "b7";

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic txReady = 1'b0;
  logic [7:0]  probeCnt = '0, protoVer = '0;
  logic [31:0] memBytes = '0, dynBytes = '0, maxRateHz = '0;
  logic txValid, done;
  logic [7:0] txData;

  int checks = 0;
  int fails = 0;

  logic [7:0] expB [0:63];
  string      expT [0:63];
  int nExp;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  metaresp_gen #(
    .NAME_LEN(NL), .NAME_TXT(NT), .FW_LEN(FL), .FW_TXT(FT),
    .AUX_LEN(AL), .AUX_TXT(AT)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .probeCnt(probeCnt),
    .memBytes(memBytes), .dynBytes(dynBytes), .maxRateHz(maxRateHz),
    .protoVer(protoVer), .txReady(txReady), .txValid(txValid),
    .txData(txData), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string t);
    expB[nExp] = b;
    expT[nExp] = t;
    nExp++;
  endtask

  task automatic pushWord(input logic [31:0] w);
    for (int k = 3; k >= 0; k--) push(8'(w >> (8 * k)), "R5");
  endtask

  task automatic buildExp();
    nExp = 0;
    push(8'h01, "R3");
    for (int k = 0; k < NL; k++) push(8'(NT >> (8 * (NL - 1 - k))), "R4");
    push(8'h00, "R4");
    push(8'h02, "R3");
    for (int k = 0; k < FL; k++) push(8'(FT >> (8 * (FL - 1 - k))), "R4");
    push(8'h00, "R4");
    push(8'h03, "R3");
    for (int k = 0; k < AL; k++) push(8'(AT >> (8 * (AL - 1 - k))), "R4");
    push(8'h00, "R4");
    push(8'h20, "R3"); pushWord({24'd0, probeCnt});
    push(8'h21, "R3"); pushWord(memBytes);
    push(8'h22, "R3"); pushWord(dynBytes);
    push(8'h23, "R3"); pushWord(maxRateHz);
    push(8'h41, "R3"); push(protoVer, "R6");
    push(8'h00, "R7");
  endtask

  task automatic runOne(input int pat, input bit inject);
    int got;
    int cyc;
    logic [7:0] held;
    bit holdPend;
    buildExp();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(txValid && txData == 8'h01, "R2", {txValid, txData}, 9'h101);
    got = 0; cyc = 0; holdPend = 0; held = '0;
    forever begin
      if (holdPend) begin
        chk(txValid && txData == held, "R8", {txValid, txData}, {1'b1, held});
        holdPend = 0;
      end
      if (done) break;
      case (pat)
        0: txReady = 1'b1;
        1: txReady = cyc[0];
        2: txReady = lfsr[0];
        default: txReady = (cyc % 4 == 3);
      endcase
      start = inject && (cyc == 6 || cyc == 7);
      #1;
      if (txValid && txReady) begin
        if (got < nExp) chk(txData == expB[got], expT[got], txData, expB[got]);
        else chk(1'b0, "R7", got, nExp);
        got++;
      end else if (txValid) begin
        held = txData;
        holdPend = 1;
      end
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (cyc > 3000) begin
        chk(1'b0, "R7", got, nExp);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(!txValid, "R7", txValid, 0);
    chk(got == nExp, inject ? "R9" : "R7", got, nExp);
    txReady = 1'b0;
    @(negedge clk);
    chk(!done && !txValid, "R7", {done, txValid}, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!txValid && !done, "R1", {txValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!txValid && !done, "R1", {txValid, done}, 0);
    for (int v = 0; v < 3; v++) begin
      case (v)
        0: begin
          probeCnt = 8'd32; memBytes = 32'h12345678; dynBytes = 32'hA0B0C0D0;
          maxRateHz = 32'd200_000_000; protoVer = 8'd2;
        end
        1: begin
          probeCnt = 8'hFF; memBytes = '1; dynBytes = '1;
          maxRateHz = '1; protoVer = 8'hFF;
        end
        default: begin
          probeCnt = 8'd0; memBytes = '0; dynBytes = 32'h00010203;
          maxRateHz = 32'h80000001; protoVer = 8'd0;
        end
      endcase
      for (int p = 0; p < 4; p++) runOne(p, p >= 2);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule